// File: doc/BRIEF.md
# Overcurrent Fault-Integration Timer

This block turns an overcurrent comparator flag into the staged protection response of a resonant converter controller. An internal saturating up/down count takes the place of a timing capacitor. The count charges while overcurrent is present and bleeds away one step per decay tick. Three ordered count thresholds set the response:

- The middle (force) threshold drives the switching frequency to its maximum and keeps the charge source on.
- The upper (shutdown) threshold stops switching and lets the count only decay.
- The lower (restart) threshold ends the stopped phase, and switching resumes through a soft-start.

Under a hard short circuit this gives hiccup operation with a low average input power.

The overcurrent flag also holds the soft-start discharged by itself, whatever the timer is doing. A separate request asks the power-factor pre-regulator to stop. That request is raised when the force threshold is reached and dropped only after the count has fallen below the restart threshold.

The three thresholds must obey restart < force < shutdown and fit within the count range. The top module refuses to elaborate otherwise. Analog sensing and capacitor physics are outside this block.

Top module: `ocp_fault_timer`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears the count to zero and returns the timer to its normal phase. Afterwards `force_max`, `stop_sw` and `pfc_stop` are low, and `ss_reset` equals `oc_flag`.
- R2: In a cycle with charging active, the count rises by `CHARGE_STEP`, saturating at 2^`CNT_W`-1. Otherwise a high `decay_tick` lowers it by one, saturating at zero. With neither, the count holds.
- R3: `ss_reset` is high in every cycle in which `oc_flag` is high, in every phase.
- R4: In the normal phase, charging follows `oc_flag`. One clock after the count is at or above `TH_FORCE`, `force_max`, `ss_reset` and `pfc_stop` go high. While `force_max` is high, charging continues whatever `oc_flag` is.
- R5: While `force_max` is high, one clock after the count is at or above `TH_SHUT`, `stop_sw` goes high and `force_max` goes low. While `stop_sw` is high, charging is off, so the count only decays.
- R6: While `stop_sw` is high, one clock after the count is below `TH_RESTART`, `stop_sw` and `pfc_stop` fall. `ss_reset` then follows `oc_flag` again, so switching restarts from a discharged soft-start.
- R7: `pfc_stop` is high exactly when `force_max` or `stop_sw` is high.
- R8: `force_max` and `stop_sw` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_flag | input | 1 | Overcurrent comparator flag (already hysteretic) |
| decay_tick | input | 1 | Enables one count of decay this cycle |
| force_max | output | 1 | Drive the oscillator to maximum frequency |
| stop_sw | output | 1 | Stop switching of both gate drivers |
| ss_reset | output | 1 | Hold the soft-start capacitor discharged |
| pfc_stop | output | 1 | Request the pre-regulator to stop |

## Verification
The bound assertions check the following on every cycle:
- the count arithmetic, including both saturation limits;
- the one-cycle response to each threshold crossing;
- the latched charging while the frequency is forced, and the absence of charging while stopped;
- the consistency of the request outputs with each other.

Only the bench's scenarios show the following:
- the full hiccup sequence;
- a charge that starts from a count that decayed while already at zero;
- reset in the middle of a stopped phase;
- long random overcurrent bursts that sometimes fall short of the force threshold.

These are compared cycle by cycle against a reference model built from the requirements.

// File: rtl/oft_pkg.sv
// Shared types for the overcurrent fault-integration timer.
// Assumes: only three phases are needed; the fourth encoding is unused.
package oft_pkg;
    typedef enum logic [1:0] {
        PH_NORMAL = 2'd0,
        PH_FORCED = 2'd1,
        PH_HALTED = 2'd2
    } oft_phase_e;
endpackage

// File: rtl/oft_counter.sv
// Saturating up/down count modelling the fault timing capacitor.
// Charging has priority over decay. Assumes CHARGE_STEP < 2**CNT_W.
module oft_counter #(
    parameter int CNT_W       = 10,
    parameter int CHARGE_STEP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             charge,
    input  logic             decay,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W:0] STEP_V = (CNT_W+1)'(CHARGE_STEP);
    localparam logic [CNT_W:0] MAX_V  = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] count_nxt;

    // Next count: saturating add while charging, else saturating decrement on a tick.
    always_comb begin
        sum = {1'b0, count} + STEP_V;
        if (charge) begin
            count_nxt = (sum > MAX_V) ? MAX_V[CNT_W-1:0] : sum[CNT_W-1:0];
        end else if (decay && (count != '0)) begin
            count_nxt = count - 1'b1;
        end else begin
            count_nxt = count;
        end
    end

    // Count register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end
endmodule

// File: rtl/oft_compare.sv
// Compares the count against the three ordered thresholds.
// Assumes every threshold fits within CNT_W bits; index 0 is restart, 1 force, 2 shutdown.
module oft_compare #(
    parameter int CNT_W      = 10,
    parameter int TH_RESTART = 30,
    parameter int TH_FORCE   = 200,
    parameter int TH_SHUT    = 350
) (
    input  logic [CNT_W-1:0] count,
    output logic             below_restart,
    output logic             at_force,
    output logic             at_shut
);
    localparam int N_TH = 3;

    logic [N_TH-1:0] ge;

    // One magnitude comparator per threshold.
    for (genvar i = 0; i < N_TH; i++) begin : g_cmp
        localparam int TH_I = (i == 0) ? TH_RESTART : ((i == 1) ? TH_FORCE : TH_SHUT);
        assign ge[i] = (count >= CNT_W'(TH_I));
    end

    assign below_restart = ~ge[0];
    assign at_force      = ge[1];
    assign at_shut       = ge[2];
endmodule

// File: rtl/oft_ctrl.sv
// Phase sequencer: normal -> forced -> halted -> normal.
// Derives the charge enable and the four protection outputs.
// Assumes the threshold flags come from the registered count.
module oft_ctrl
    import oft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic below_restart,
    input  logic at_force,
    input  logic at_shut,
    output logic charge,
    output logic force_max,
    output logic stop_sw,
    output logic ss_reset,
    output logic pfc_stop
);
    oft_phase_e phase, phase_nxt;

    // Next phase from the current phase and the threshold flags.
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_NORMAL: if (at_force)      phase_nxt = PH_FORCED;
            PH_FORCED: if (at_shut)       phase_nxt = PH_HALTED;
            PH_HALTED: if (below_restart) phase_nxt = PH_NORMAL;
            default:                      phase_nxt = PH_NORMAL;
        endcase
    end

    // Phase register with synchronous return to normal.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_NORMAL;
        else        phase <= phase_nxt;
    end

    // Output decode; the charge source is latched on while forced.
    always_comb begin
        force_max = (phase == PH_FORCED);
        stop_sw   = (phase == PH_HALTED);
        pfc_stop  = force_max | stop_sw;
        charge    = force_max | ((phase == PH_NORMAL) & oc_flag);
        ss_reset  = oc_flag | pfc_stop;
    end
endmodule

// File: rtl/ocp_fault_timer.sv
// Overcurrent fault-integration timer: count, threshold compare and phase control.
// Assumes oc_flag and decay_tick are synchronous to clk. Refuses to elaborate
// unless TH_RESTART < TH_FORCE < TH_SHUT < 2**CNT_W.
module ocp_fault_timer #(
    parameter int CNT_W       = 10,
    parameter int CHARGE_STEP = 3,
    parameter int TH_RESTART  = 30,
    parameter int TH_FORCE    = 200,
    parameter int TH_SHUT     = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic decay_tick,
    output logic force_max,
    output logic stop_sw,
    output logic ss_reset,
    output logic pfc_stop
);
    localparam longint CNT_MAX = (longint'(1) << CNT_W) - 1;

    // Elaboration-time check of threshold ordering and range.
    if (!((TH_RESTART < TH_FORCE) && (TH_FORCE < TH_SHUT) && (longint'(TH_SHUT) <= CNT_MAX)))
    begin : g_bad_thresholds
        $error("ocp_fault_timer: thresholds must satisfy restart < force < shutdown <= max");
    end

    logic [CNT_W-1:0] count;
    logic             charge;
    logic             below_restart;
    logic             at_force;
    logic             at_shut;

    oft_counter #(
        .CNT_W       (CNT_W),
        .CHARGE_STEP (CHARGE_STEP)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .charge (charge),
        .decay  (decay_tick),
        .count  (count)
    );

    oft_compare #(
        .CNT_W      (CNT_W),
        .TH_RESTART (TH_RESTART),
        .TH_FORCE   (TH_FORCE),
        .TH_SHUT    (TH_SHUT)
    ) u_compare (
        .count         (count),
        .below_restart (below_restart),
        .at_force      (at_force),
        .at_shut       (at_shut)
    );

    oft_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .oc_flag       (oc_flag),
        .below_restart (below_restart),
        .at_force      (at_force),
        .at_shut       (at_shut),
        .charge        (charge),
        .force_max     (force_max),
        .stop_sw       (stop_sw),
        .ss_reset      (ss_reset),
        .pfc_stop      (pfc_stop)
    );
endmodule

// File: rtl/oft_checker.sv
// Property checker for ocp_fault_timer, attached by bind below.
// Assumes it observes the internal count and charge enable of the top module.
module oft_checker #(
    parameter int CNT_W       = 10,
    parameter int CHARGE_STEP = 3,
    parameter int TH_RESTART  = 30,
    parameter int TH_FORCE    = 200,
    parameter int TH_SHUT     = 350
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oc_flag,
    input logic             decay_tick,
    input logic             charge,
    input logic [CNT_W-1:0] count,
    input logic             force_max,
    input logic             stop_sw,
    input logic             ss_reset,
    input logic             pfc_stop
);
    localparam int MAXC = (1 << CNT_W) - 1;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !force_max && !stop_sw && !pfc_stop);

    a_r2_charge_add: assert property (@(posedge clk) disable iff (!rst_n)
        charge && (int'(count) <= MAXC - CHARGE_STEP) |=>
            int'(count) == int'($past(count)) + CHARGE_STEP);

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        charge && (int'(count) > MAXC - CHARGE_STEP) |=> int'(count) == MAXC);

    a_r2_decay_one: assert property (@(posedge clk) disable iff (!rst_n)
        !charge && decay_tick && (count != '0) |=>
            int'(count) == int'($past(count)) - 1);

    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !charge && decay_tick && (count == '0) |=> count == '0);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !charge && !decay_tick |=> $stable(count));

    a_r3_ss_on_oc: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |-> ss_reset);

    a_r4_enter_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !force_max && !stop_sw && (int'(count) >= TH_FORCE) |=> force_max && ss_reset);

    a_r4_latched_charge: assert property (@(posedge clk) disable iff (!rst_n)
        force_max |-> charge);

    a_r5_enter_halt: assert property (@(posedge clk) disable iff (!rst_n)
        force_max && (int'(count) >= TH_SHUT) |=> stop_sw && !force_max);

    a_r5_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
        stop_sw |-> !charge);

    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        stop_sw && (int'(count) < TH_RESTART) |=> !stop_sw && !pfc_stop);

    a_r7_pfc_match: assert property (@(posedge clk) disable iff (!rst_n)
        pfc_stop == (force_max || stop_sw));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({force_max, stop_sw}));
endmodule

bind ocp_fault_timer oft_checker #(
    .CNT_W       (CNT_W),
    .CHARGE_STEP (CHARGE_STEP),
    .TH_RESTART  (TH_RESTART),
    .TH_FORCE    (TH_FORCE),
    .TH_SHUT     (TH_SHUT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_flag    (oc_flag),
    .decay_tick (decay_tick),
    .charge     (charge),
    .count      (count),
    .force_max  (force_max),
    .stop_sw    (stop_sw),
    .ss_reset   (ss_reset),
    .pfc_stop   (pfc_stop)
);

// File: tb/ocp_fault_timer_tb.sv
// Self-checking bench: directed corner cases plus seeded random overcurrent bursts,
// compared every cycle against a reference model written from the requirements.
module ocp_fault_timer_tb;
    localparam int CNT_W      = 10;
    localparam int STEP       = 3;
    localparam int TH_RESTART = 30;
    localparam int TH_FORCE   = 200;
    localparam int TH_SHUT    = 350;
    localparam int MAXC       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 1'b0;
    logic decay_tick = 1'b0;
    logic force_max, stop_sw, ss_reset, pfc_stop;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state: phase 0 normal, 1 forced, 2 halted.
    int m_cnt = 0;
    int m_ph  = 0;

    always #10 clk = ~clk;

    ocp_fault_timer #(
        .CNT_W       (CNT_W),
        .CHARGE_STEP (STEP),
        .TH_RESTART  (TH_RESTART),
        .TH_FORCE    (TH_FORCE),
        .TH_SHUT     (TH_SHUT)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_flag    (oc_flag),
        .decay_tick (decay_tick),
        .force_max  (force_max),
        .stop_sw    (stop_sw),
        .ss_reset   (ss_reset),
        .pfc_stop   (pfc_stop)
    );

    // R2 model: saturating charge, else saturating decay on a tick.
    function automatic int next_cnt(int c, int ph, bit oc, bit tk);
        bit chg = (ph == 1) || ((ph == 0) && oc);
        if (chg) return (c + STEP > MAXC) ? MAXC : c + STEP;
        if (tk && c > 0) return c - 1;
        return c;
    endfunction

    // R4-R6 model: phase advance from the current count.
    function automatic int next_ph(int c, int ph);
        if (ph == 0 && c >= TH_FORCE)   return 1;
        if (ph == 1 && c >= TH_SHUT)    return 2;
        if (ph == 2 && c < TH_RESTART)  return 0;
        return ph;
    endfunction

    // Expected {force_max, stop_sw, ss_reset, pfc_stop} for the model state.
    function automatic logic [3:0] exp_outs(int ph, bit oc);
        return {ph == 1, ph == 2, oc || (ph != 0), ph != 0};
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {force,stop,ss,pfc} actual=%b expected=%b (model cnt=%0d ph=%0d)",
                     tag, got, exp, m_cnt, m_ph);
        end
    endtask

    // One clock: drive at negedge, check, then advance the model at posedge.
    task automatic step(input bit oc, input bit tk, input string tag);
        string t;
        @(negedge clk);
        oc_flag = oc;
        decay_tick = tk;
        #1;
        if (tag != "")      t = tag;
        else if (m_ph == 1) t = "R4";
        else if (m_ph == 2) t = "R5";
        else if (oc)        t = "R3";
        else                t = "R6";
        check(t, {force_max, stop_sw, ss_reset, pfc_stop}, exp_outs(m_ph, oc));
        @(posedge clk);
        begin
            int nc = next_cnt(m_cnt, m_ph, oc, tk);
            m_ph  = next_ph(m_cnt, m_ph);
            m_cnt = nc;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        oc_flag = 1'b0;
        decay_tick = 1'b0;
        @(posedge clk);
        m_cnt = 0;
        m_ph  = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        do_reset();
        // R1: reset state with oc low, then ss_reset must follow oc.
        step(1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");

        // R2: decay long at zero must not wrap; the following charge needs the full climb.
        do_reset();
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, "R2");
        for (int i = 0; i < 66; i++) step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, "R4");

        // R3: a short burst stays below force; ss_reset follows oc only.
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R3");
        for (int i = 0; i < 80; i++) step(1'b0, 1'b1, "R3");

        // R4/R5/R6: full hiccup cycle; oc dropped while forced must not stop charging.
        do_reset();
        for (int i = 0; i < 70; i++)  step(1'b1, 1'b0, "");
        for (int i = 0; i < 60; i++)  step(1'b0, 1'b0, "R4");
        for (int i = 0; i < 400; i++) step(1'b0, 1'b1, "");
        for (int i = 0; i < 5; i++)   step(1'b0, 1'b1, "R6");

        // R1: reset in the middle of a stopped phase.
        for (int i = 0; i < 130; i++) step(1'b1, 1'b1, "");
        do_reset();
        step(1'b0, 1'b0, "R1");

        // Random bursts of overcurrent with random decay ticks.
        begin
            bit oc = 1'b0;
            for (int i = 0; i < 20000; i++) begin
                if (($urandom % 60) == 0) oc = ~oc;
                step(oc, ($urandom % 2) == 0, "");
                n_checks++;  // R7: pfc_stop tracks force_max or stop_sw
                if (pfc_stop !== (force_max | stop_sw)) begin
                    n_fail++;
                    $display("FAIL R7: pfc_stop actual=%b expected=%b", pfc_stop, force_max | stop_sw);
                end
                n_checks++;  // R8: forced and stopped are exclusive
                if (force_max && stop_sw) begin
                    n_fail++;
                    $display("FAIL R8: {force,stop} actual=%b%b expected not 11", force_max, stop_sw);
                end
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule